// File: doc/BRIEF.md
# Four-Phase Handshake Bus Target

This block is a clocked target that answers transfers on a simple asynchronous parallel bus. A master starts a transfer by pulling an active-low select low while it holds a read-not-write flag, a 16-bit address and 8-bit write data stable. The target finishes the transfer by pulling an active-low done low, and for reads it presents 8-bit read data at that moment. The master then raises select, and the target raises done again. Only after that may a new transfer begin. Every transfer is this full return-to-idle exchange.

Select comes from a foreign timing domain. It passes through a two-stage synchroniser before the sequencer acts on it. The other bus lines are captured only once the synchronised select is low. Behind the bus sits a 256-byte store indexed by the low address byte. A parameter adds a chosen number of clocks between capture and the fall of done, so the block can model slower targets. A bus reset returns the target to idle and makes every location read as zero until it is written again.

Top module: `hs_bus_target`

## Requirements
- R1: While reset is applied and after it is released, bus_done_n is 1 and bus_rdata is 0. Every location reads 0 until it is written after the last reset.
- R2: Take the first rising clock edge after bus_sel_n falls as edge 1. With the default two synchroniser stages, bus_done_n falls at edge RESP_DELAY+4.
- R3: bus_rnw = 1 selects a read. When bus_done_n falls, bus_rdata already holds the byte stored at the captured bus_addr[7:0].
- R4: bus_rnw = 0 selects a write. bus_wdata is stored at bus_addr[7:0] and returned by later reads of that index.
- R5: bus_addr[15:8] has no effect. Addresses with equal low bytes select the same location.
- R6: bus_done_n stays low for as long as bus_sel_n stays low. Take the first edge after bus_sel_n rises as edge 1: bus_done_n returns to 1 at edge 3. It then stays 1 until bus_sel_n falls again.
- R7: A transfer commits at most one write, using the bus values captured at its start. Bus inputs that change while bus_done_n is low have no effect.
- R8: Suppose bus_sel_n rises before bus_done_n has fallen. The transfer is then abandoned: bus_done_n never falls and nothing is written.
- R9: bus_rdata changes only when a read completes. Writes, aborts and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Bus reset, active low; asserts asynchronously and is released synchronously inside the block |
| bus_sel_n | input | 1 | Transfer select from the master, active low, asynchronous |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Transfer address; only the low byte indexes the store |
| bus_wdata | input | 8 | Write data from the master |
| bus_done_n | output | 1 | Completion indication, active low |
| bus_rdata | output | 8 | Read data, valid when bus_done_n falls on a read |

## Verification
A vector table runs a mix of reads and writes. It includes a read of an unwritten location, writes at the lowest and highest index, an overwrite, and a write whose address differs from its read only in the high byte. Together these separate correct indexing from aliasing, stale data and address-width mistakes. Every transfer also measures the cycle counts for done falling and rising. These counts catch a synchroniser that is too short or too long and a miscounted response delay. Directed cases cover the rest: a select held low while the bus lines change, an early release that must abort, reads after a reset, and a write between reads. These separate single commit, the abort path, clearing of the store and holding of the read data.

// File: rtl/hs_bus_pkg.sv
package hs_bus_pkg;

  localparam int HS_ADDR_W = 16;
  localparam int HS_DATA_W = 8;
  localparam int HS_IDX_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } hs_state_e;

  typedef struct packed {
    logic                 rnw;
    logic [HS_IDX_W-1:0]  idx;
    logic [HS_DATA_W-1:0] wdata;
  } hs_req_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_bus_pkg::*;
#(
  parameter int RESP_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sync,
  output logic done_n,
  output logic cap_en,
  output logic commit
);

  localparam int CNT_W = (RESP_DELAY < 1) ? 1 : $clog2(RESP_DELAY + 1);
  localparam logic [CNT_W-1:0] DELAY_C = CNT_W'(RESP_DELAY);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    cap_en  = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        done_d = 1'b1;
        if (!sel_sync) begin
          cap_en  = 1'b1;
          cnt_d   = '0;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (sel_sync) begin
          state_d = ST_IDLE;            // early release: abandon
        end else if (cnt_q == DELAY_C) begin
          commit  = 1'b1;
          done_d  = 1'b0;
          state_d = ST_ACK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACK: begin
        if (sel_sync) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign cnt_en = (state_q != ST_ACK);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign done_n = done_q;

endmodule

// File: rtl/hs_byte_store.sv
module hs_byte_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;

  // storage array carries no reset; a valid bit per location masks stale content
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q      <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  always_comb begin
    rd_word = vld_q[idx] ? mem_q[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/hs_bus_target.sv
module hs_bus_target
  import hs_bus_pkg::*;
#(
  parameter int ADDR_W      = HS_ADDR_W,
  parameter int DATA_W      = HS_DATA_W,
  parameter int IDX_W       = HS_IDX_W,
  parameter int RESP_DELAY  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_done_n,
  output logic [DATA_W-1:0] bus_rdata
);

  logic    rst_sync_n;
  logic    sel_sync;
  logic    cap_en;
  logic    commit;
  logic    wr_commit;
  logic    rd_commit;
  hs_req_t req_q;
  logic    unused_addr_hi;

  // reset: asserted at once, released on the clock
  hs_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  hs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (bus_sel_n),
    .q     (sel_sync)
  );

  hs_seq_fsm #(.RESP_DELAY(RESP_DELAY)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sel_sync (sel_sync),
    .done_n   (bus_done_n),
    .cap_en   (cap_en),
    .commit   (commit)
  );

  // bus lines are sampled only once synchronised select is low
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= '0;
    end else if (cap_en) begin
      req_q.rnw   <= bus_rnw;
      req_q.idx   <= bus_addr[IDX_W-1:0];
      req_q.wdata <= bus_wdata;
    end
  end

  assign wr_commit      = commit & ~req_q.rnw;
  assign rd_commit      = commit &  req_q.rnw;
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:IDX_W];

  hs_byte_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_commit),
    .rd_en (rd_commit),
    .idx   (req_q.idx),
    .wdata (req_q.wdata),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/hs_bus_target_chk.sv
module hs_bus_target_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_sync,
  input logic              done_n,
  input logic              wr_commit,
  input logic              rd_commit,
  input logic [DATA_W-1:0] rdata
);

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_n && !sel_sync) |=> !done_n); // R6

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_n && sel_sync) |=> done_n); // R6

  AST_DONE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> !$past(sel_sync)); // R2

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R7

  AST_NO_COMMIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sync |-> !(wr_commit || rd_commit)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_commit |=> $stable(rdata)); // R9

endmodule

bind hs_bus_target hs_bus_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_sync  (sel_sync),
  .done_n    (bus_done_n),
  .wr_commit (wr_commit),
  .rd_commit (rd_commit),
  .rdata     (bus_rdata)
);

// File: tb/tb_hs_bus_target.sv
module tb_hs_bus_target;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 2;
  localparam int EXP_FALL   = DLY + 4;
  localparam int EXP_RISE   = 3;
  localparam int NV         = 11;

  // {rnw, addr, wdata, expected read data}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h0005, 8'h00, 8'h00},   // unwritten location reads 0 (R1)
    {1'b0, 16'h0005, 8'h5A, 8'h00},
    {1'b1, 16'h0005, 8'h00, 8'h5A},
    {1'b0, 16'h00FF, 8'hC3, 8'h00},
    {1'b0, 16'h0000, 8'h11, 8'h00},
    {1'b1, 16'h00FF, 8'h00, 8'hC3},
    {1'b1, 16'h0000, 8'h00, 8'h11},
    {1'b0, 16'hAB07, 8'hE7, 8'h00},   // high address byte ignored (R5)
    {1'b1, 16'h0007, 8'h00, 8'hE7},
    {1'b0, 16'h0005, 8'hA5, 8'h00},
    {1'b1, 16'h3405, 8'h00, 8'hA5}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_sel_n;
  logic        bus_rnw;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_done_n;
  logic [7:0]  bus_rdata;

  int total;
  int bad;

  hs_bus_target #(.RESP_DELAY(DLY)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_n  (bus_sel_n),
    .bus_rnw    (bus_rnw),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_done_n (bus_done_n),
    .bus_rdata  (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic rnw, input logic [15:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int fall_n, output int rise_n);
    @(negedge clk);
    bus_rnw   = rnw;
    bus_addr  = a;
    bus_wdata = d;
    bus_sel_n = 1'b0;
    fall_n = 0;
    do begin
      @(negedge clk);
      fall_n++;
    end while (bus_done_n && fall_n < 100);
    rd = bus_rdata;
    bus_sel_n = 1'b1;
    rise_n = 0;
    do begin
      @(negedge clk);
      rise_n++;
    end while (!bus_done_n && rise_n < 100);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int         fn;
    int         rn;
    int         cnt;
    total     = 0;
    bad       = 0;
    rst_n     = 1'b0;
    bus_sel_n = 1'b1;
    bus_rnw   = 1'b1;
    bus_addr  = '0;
    bus_wdata = '0;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 done during reset", int'(bus_done_n), 1);
    chk("R1 rdata during reset", int'(bus_rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(bus_done_n), 1);
    chk("R1 rdata after reset", int'(bus_rdata), 0);

    // vector table: R2 fall latency, R6 release, R3/R4/R5 data
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][32], VEC[i][31:16], VEC[i][15:8], rd, fn, rn);
      chk("R2 done fall latency", fn, EXP_FALL);
      chk("R6 done release latency", rn, EXP_RISE);
      if (VEC[i][32]) chk("R3 R4 R5 read data", int'(rd), int'(VEC[i][7:0]));
    end

    // R6: done stays high while select stays high
    cnt = 0;
    repeat (10) begin
      @(negedge clk);
      if (!bus_done_n) cnt++;
    end
    chk("R6 done idle without select", cnt, 0);

    // R7: long hold with bus lines changing after done falls
    @(negedge clk);
    bus_rnw = 1'b0; bus_addr = 16'h0040; bus_wdata = 8'h3C; bus_sel_n = 1'b0;
    fn = 0;
    do begin @(negedge clk); fn++; end while (bus_done_n && fn < 100);
    chk("R7 hold fall latency", fn, EXP_FALL);
    bus_addr = 16'h0041; bus_wdata = 8'hFF; bus_rnw = 1'b1;
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      if (bus_done_n) cnt++;
    end
    chk("R6 done held low during long select", cnt, 0);
    bus_sel_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(1'b1, 16'h0040, 8'h00, rd, fn, rn);
    chk("R7 captured write data kept", int'(rd), 8'h3C);
    xfer(1'b1, 16'h0041, 8'h00, rd, fn, rn);
    chk("R7 late address change ignored", int'(rd), 0);

    // R9: rdata unchanged by a write and by idle cycles
    xfer(1'b1, 16'h0040, 8'h00, rd, fn, rn);
    xfer(1'b0, 16'h0060, 8'h99, rd, fn, rn);
    chk("R9 rdata after write", int'(bus_rdata), 8'h3C);
    repeat (5) @(negedge clk);
    chk("R9 rdata after idle", int'(bus_rdata), 8'h3C);

    // R8: early release abandons the transfer
    @(negedge clk);
    bus_rnw = 1'b0; bus_addr = 16'h0050; bus_wdata = 8'h77; bus_sel_n = 1'b0;
    @(negedge clk);
    bus_sel_n = 1'b1;
    cnt = 0;
    repeat (12) begin
      @(negedge clk);
      if (!bus_done_n) cnt++;
    end
    chk("R8 no done on abort", cnt, 0);
    chk("R9 rdata after abort", int'(bus_rdata), 8'h3C);
    xfer(1'b1, 16'h0050, 8'h00, rd, fn, rn);
    chk("R8 no write on abort", int'(rd), 0);

    // R1: reset clears the store and the read data
    xfer(1'b1, 16'h0005, 8'h00, rd, fn, rn);
    chk("R1 pre-reset value present", int'(rd), 8'hA5);
    do_reset();
    chk("R1 rdata cleared by reset", int'(bus_rdata), 0);
    xfer(1'b1, 16'h0005, 8'h00, rd, fn, rn);
    chk("R1 location cleared by reset", int'(rd), 0);
    xfer(1'b1, 16'h00FF, 8'h00, rd, fn, rn);
    chk("R1 top location cleared by reset", int'(rd), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule